// File: doc/BRIEF.md
# Streaming Run-Length Byte Encoder

This block compresses a stream of bytes as they arrive, one byte per clock edge while `inValid` is high. It follows the current run of identical bytes. When the run ends, it writes that run into an output queue in one of two forms. The first form is a three-byte record made of the marker byte 0x1B, a count and the byte value. The second form is the run's bytes passed through unchanged. The queue then drains onto an 8-bit output at most one byte per two cycles. Each byte is announced by a single-cycle pulse on `dataValid`.

Any run of the marker byte itself is always turned into a record. A single marker byte is therefore never emitted bare, so a decoder can always tell a record apart from literal data. A run that reaches fifteen bytes is closed at once. Further identical bytes start a fresh run. Raising `flush` at the end of a stream closes whatever run is still open.

The producer must keep its average input rate within what the queue can absorb. A long stream of isolated bytes arriving on every cycle produces bytes faster than the output drains them.

Top module: `rle_byte_encoder`

## Requirements
- R1: A synchronous active-high `rst` forces `dataValid` low on the next edge. It discards the queued output bytes and the open run, so a later flush emits nothing.
- R2: A run of 1 or 2 copies of a byte other than 0x1B is emitted as those same bytes, unchanged.
- R3: A run of n copies of a byte c other than 0x1B, with 3 ≤ n ≤ 15, is emitted as 0x1B, then n, then c. The count byte holds n in its low 4 bits, and its upper 4 bits are zero.
- R4: A run of n copies of 0x1B, with 1 ≤ n ≤ 15, is emitted as 0x1B, n, 0x1B. This includes a lone 0x1B.
- R5: A run is closed and encoded as soon as it holds 15 bytes. The next identical byte opens a new run of length 1, and the run counter never holds more than 14.
- R6: `dataValid` is never high on two consecutive cycles. `dataOut` changes only on the edge where `dataValid` rises.
- R7: Output bytes appear in the order their runs ended. The queue is never written past its capacity.
- R8: While `flush` is high, the open run is closed and encoded, and `inValid` is ignored in that cycle. A flush with no open run emits nothing.
- R9: Cycles with `inValid` low neither break nor extend the open run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | `inByte` is taken on this edge |
| inByte | input | 8 | Input byte |
| flush | input | 1 | Close and encode the open run; input is ignored this cycle |
| dataValid | output | 1 | One-cycle pulse marking a new output byte |
| dataOut | output | 8 | Output byte, held until the next pulse |

## Verification
A miscounted run or a wrong close point shows up in the first record after the fault, as a count byte that is off. It can also show up as a record split in the wrong place, or as raw bytes where a record was due. This appears within two output pulses of the run ending. A corrupted queue pointer shows up as bytes that are repeated, lost or reordered from the next drained byte onward. A broken output strobe shows up as two adjacent high cycles on `dataValid`. Every run length from 1 to 17 is swept for an ordinary byte and for the marker byte. The streams that follow cover the transitions between different runs, idle gaps, flush corners and a reset in mid-stream.

// File: rtl/rle_pkg.sv
package rle_pkg;
  localparam logic [7:0] ESC_BYTE = 8'h1B;
  localparam int CNT_W = 4;
  localparam int RUN_MAX = 15;
  localparam int REC_BYTES = 3;

  // strobes from the run control into the queue datapath
  typedef struct packed {
    logic [1:0] pushCount;
    logic [7:0] byte0;
    logic [7:0] byte1;
    logic [7:0] byte2;
  } pushReq_t;
endpackage

// File: rtl/rle_run_ctrl.sv
module rle_run_ctrl
  import rle_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [7:0] inByte,
  input  logic       flush,
  output pushReq_t   pushReq
);
  logic [7:0]       curByte, nextByte;
  logic [CNT_W-1:0] runCount, nextCount, closeLen;
  logic             closeRun;

  always_comb begin
    closeRun  = 1'b0;
    closeLen  = runCount;
    nextCount = runCount;
    nextByte  = curByte;
    if (flush) begin
      closeRun  = (runCount != '0);
      nextCount = '0;
    end else if (inValid) begin
      if (runCount == '0) begin
        nextCount = CNT_W'(1);
        nextByte  = inByte;
      end else if (inByte == curByte) begin
        if (runCount == CNT_W'(RUN_MAX - 1)) begin
          closeRun  = 1'b1;
          closeLen  = CNT_W'(RUN_MAX);
          nextCount = '0;
        end else begin
          nextCount = runCount + CNT_W'(1);
        end
      end else begin
        closeRun  = 1'b1;
        nextCount = CNT_W'(1);
        nextByte  = inByte;
      end
    end
  end

  always_comb begin
    pushReq = '0;
    if (closeRun) begin
      if (curByte == ESC_BYTE || closeLen >= CNT_W'(3)) begin
        pushReq.pushCount = 2'(REC_BYTES);
        pushReq.byte0     = ESC_BYTE;
        pushReq.byte1     = {{(8-CNT_W){1'b0}}, closeLen};
        pushReq.byte2     = curByte;
      end else begin
        pushReq.pushCount = closeLen[1:0];
        pushReq.byte0     = curByte;
        pushReq.byte1     = curByte;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      runCount <= '0;
      curByte  <= '0;
    end else begin
      runCount <= nextCount;
      curByte  <= nextByte;
    end
  end

  assert_count_cap_R5: assert property (@(posedge clk) disable iff (rst)
    runCount <= CNT_W'(RUN_MAX - 1));
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> runCount == '0);
  assert_idle_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (!inValid && !flush) |=> ($stable(runCount) && $stable(curByte)));
endmodule

// File: rtl/rle_out_queue.sv
module rle_out_queue
  import rle_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  pushReq_t   pushReq,
  output logic       dataValid,
  output logic [7:0] dataOut
);
  localparam int AW = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];
  logic [7:0] pushData [REC_BYTES];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [AW:0]   level;
  logic          popNow;

  assign pushData[0] = pushReq.byte0;
  assign pushData[1] = pushReq.byte1;
  assign pushData[2] = pushReq.byte2;
  assign popNow = !dataValid && (level != '0);

  always_ff @(posedge clk) begin
    for (int k = 0; k < REC_BYTES; k++) begin
      if (k < int'(pushReq.pushCount))
        mem[wrPtr + AW'(k)] <= pushData[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      level     <= '0;
      dataValid <= 1'b0;
      dataOut   <= '0;
    end else begin
      wrPtr <= wrPtr + AW'(pushReq.pushCount);
      rdPtr <= rdPtr + AW'(popNow);
      level <= level + (AW+1)'(pushReq.pushCount) - (AW+1)'(popNow);
      if (popNow) begin
        dataValid <= 1'b1;
        dataOut   <= mem[rdPtr];
      end else begin
        dataValid <= 1'b0;
      end
    end
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    (32'(level) + 32'(pushReq.pushCount)) <= DEPTH);
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    dataValid |=> !dataValid);
  assert_hold_byte_R6: assert property (@(posedge clk) disable iff (rst)
    !dataValid |=> (dataValid || $stable(dataOut)));
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> !dataValid);
endmodule

// File: rtl/rle_byte_encoder.sv
module rle_byte_encoder
  import rle_pkg::*;
#(
  parameter int FIFO_DEPTH = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic [7:0] inByte,
  input  logic       flush,
  output logic       dataValid,
  output logic [7:0] dataOut
);
  pushReq_t pushReq;

  rle_run_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inByte  (inByte),
    .flush   (flush),
    .pushReq (pushReq)
  );

  rle_out_queue #(.DEPTH(FIFO_DEPTH)) u_queue (
    .clk       (clk),
    .rst       (rst),
    .pushReq   (pushReq),
    .dataValid (dataValid),
    .dataOut   (dataOut)
  );
endmodule

// File: tb/rle_byte_encoder_bench.sv
module rle_byte_encoder_bench;
  localparam logic [7:0] ESC = 8'h1B;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic inValid = 1'b0;
  logic [7:0] inByte = '0;
  logic flush = 1'b0;
  logic dataValid;
  logic [7:0] dataOut;

  int checks = 0;
  int errors = 0;
  logic [7:0] expQ [512];
  logic [7:0] capQ [512];
  int expN = 0;
  int capN = 0;
  int pulseViol = 0;
  logic prevValid = 1'b0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rle_byte_encoder u_rle_byte_encoder (
    .clk(clk), .rst(rst), .inValid(inValid), .inByte(inByte),
    .flush(flush), .dataValid(dataValid), .dataOut(dataOut)
  );

  always @(negedge clk) begin
    if (!rst && dataValid) begin
      if (prevValid) pulseViol++;
      if (capN < 512) capQ[capN] = dataOut;
      capN++;
    end
    prevValid = dataValid;
  end

  task automatic expect1(input logic [7:0] b);
    expQ[expN] = b;
    expN++;
  endtask

  task automatic addRun(input logic [7:0] c, input int n);
    int left = n;
    while (left > 0) begin
      int k = (left > 15) ? 15 : left;
      if (c == ESC || k >= 3) begin
        expect1(ESC); expect1(8'(k)); expect1(c);
      end else begin
        for (int i = 0; i < k; i++) expect1(c);
      end
      left -= k;
    end
  endtask

  task automatic sendRun(input logic [7:0] c, input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); inValid = 1'b1; inByte = c;
      if (gap > 0) begin
        @(negedge clk); inValid = 1'b0;
        repeat (gap - 1) @(negedge clk);
      end
    end
  endtask

  task automatic startScen;
    expN = 0; capN = 0; pulseViol = 0;
  endtask

  task automatic endStream(input int drain);
    @(negedge clk); inValid = 1'b0; flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    repeat (drain) @(negedge clk);
  endtask

  task automatic compare(input string tag, input string name);
    checks++;
    if (capN != expN) begin
      errors++;
      $display("FAIL %s %s: byte count actual %0d expected %0d", tag, name, capN, expN);
    end
    for (int i = 0; i < expN && i < capN; i++) begin
      checks++;
      if (capQ[i] !== expQ[i]) begin
        errors++;
        $display("FAIL %s %s: byte %0d actual %02h expected %02h", tag, name, i, capQ[i], expQ[i]);
      end
    end
    checks++;
    if (pulseViol != 0) begin
      errors++;
      $display("FAIL R6 %s: back-to-back dataValid actual %0d expected 0", name, pulseViol);
    end
  endtask

  task automatic finish;
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (dataValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: dataValid actual %b expected 0", dataValid);
    end
    rst = 1'b0;

    // sweep of run lengths, ordinary and marker byte (R2 R3 R4 R5)
    for (int sel = 0; sel < 2; sel++) begin
      for (int n = 1; n <= 17; n++) begin
        logic [7:0] c = (sel == 0) ? 8'h61 : ESC;
        string tag;
        if (sel == 1) tag = (n > 15) ? "R5" : "R4";
        else tag = (n <= 2) ? "R2" : (n <= 15) ? "R3" : "R5";
        startScen();
        addRun(c, n);
        sendRun(c, n, 0);
        endStream(20);
        compare(tag, $sformatf("sweep byte %02h len %0d", c, n));
      end
    end

    // R7: back-to-back mixed runs keep order
    startScen();
    addRun(8'h41, 1); addRun(8'h42, 2); addRun(ESC, 1); addRun(8'h43, 3);
    addRun(8'h44, 1); addRun(ESC, 2); addRun(8'h45, 20);
    sendRun(8'h41, 1, 0); sendRun(8'h42, 2, 0); sendRun(ESC, 1, 0);
    sendRun(8'h43, 3, 0); sendRun(8'h44, 1, 0); sendRun(ESC, 2, 0);
    sendRun(8'h45, 20, 0);
    endStream(80);
    compare("R7", "mixed stream");

    // R9: idle gaps inside runs
    startScen();
    addRun(8'h78, 4); addRun(8'h79, 2);
    sendRun(8'h78, 4, 2); sendRun(8'h79, 2, 3);
    endStream(30);
    compare("R9", "gapped runs");

    // R8: input ignored in flush cycle, empty flush emits nothing
    startScen();
    addRun(8'h51, 2);
    sendRun(8'h51, 2, 0);
    @(negedge clk); inValid = 1'b1; inByte = 8'h5A; flush = 1'b1;
    @(negedge clk); inValid = 1'b0; flush = 1'b0;
    repeat (20) @(negedge clk);
    endStream(20);
    compare("R8", "flush ignores input");

    // R1: reset mid-stream drops queue and open run
    startScen();
    sendRun(8'h4D, 3, 0); sendRun(8'h4E, 1, 0);
    @(negedge clk); inValid = 1'b0; rst = 1'b1;
    @(negedge clk);
    checks++;
    if (dataValid !== 1'b0) begin
      errors++;
      $display("FAIL R1 mid reset: dataValid actual %b expected 0", dataValid);
    end
    @(negedge clk); rst = 1'b0;
    endStream(30);
    compare("R1", "reset mid-stream");

    finish();
  end
endmodule